// File: doc/BRIEF.md
# Multi-Lane Stereo Serial Audio Transmitter

This block sends stereo audio samples on several serial data lanes at once. The lanes share a single frame controller, one incoming bit clock and one incoming word-select line. Each lane has a holding register that the host writes and a shift register that feeds its output. Words go out left and right in turn, framed as 16, 24 or 32 bits. A 24-bit sample placed in a 32-bit frame is padded by repeating one of its bits eight times.

The bit clock and the word-select line are produced elsewhere and arrive as plain inputs. They are sampled in the system clock domain. Two flags tell the host which channel's holding registers may be refilled. When both flags are set, the host fell behind: the holding contents are sent again and the condition stays visible until the host reads status and then writes. Lanes are enabled one by one. Clearing every enable puts the section into a local reset that keeps the holding registers.

Top module: `stereo_multilane_tx`

## Requirements
- R1: `cfg_wlen` selects the frame. With 00 the frame is 16 bits long and carries bits 23..8 of the holding word. With 01 it is 24 bits long and carries the whole word. With `cfg_lsb_first`=0 bits go out from the highest index downward. With 1 they go out from the lowest index upward; in the 16-bit frame that lowest index is bit 8.
- R2: With `cfg_wlen` 10 or 11 the frame is 32 bits long. If `cfg_pad_lead`=0, the 24 word bits go out in the selected order and then the 24th bit sent is repeated 8 more times. If `cfg_pad_lead`=1, the first bit in the selected order is sent 8 times and then the full 24-bit sequence follows.
- R3: With `cfg_ws_early`=0 a word starts on the bit-clock edge at which `wsel` changes. With `cfg_ws_early`=1 it starts one bit clock after that change.
- R4: With `cfg_left_high`=0, `wsel` low marks the left word; with 1, `wsel` high marks it. With `cfg_rise_change`=0, `wsel` and `sdo` change after falling `bclk` edges; with 1, after rising edges. `sdo` follows a change edge within two `clk` cycles.
- R5: After enabling, the first word sent is a left word; a right-word select change seen first is ignored. Data written while all lanes are disabled is kept and sent in that first left slot.
- R6: When left words load into the shift registers, `right_empty` is set. When right words load, `left_empty` is set.
- R7: When exactly one empty flag is set, any data write clears it.
- R8: `underrun` is high exactly when both flags are set. In that state the holding contents, unchanged since the last write, are sent again.
- R9: With both flags set, a write alone clears nothing. A `stat_rd` pulse followed by a later write clears both flags.
- R10: A disabled lane drives `sdo` high. An enabled lane drives low while no word is in progress.
- R11: After reset, and while every lane enable is low, both flags and `underrun` are low.
- R12: All enabled lanes load together and shift on the same bit-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | LANES | Per-lane enable; all low puts the section in local reset |
| cfg_wlen | input | 2 | Frame length code |
| cfg_lsb_first | input | 1 | Bit order: 0 high index first, 1 low index first |
| cfg_pad_lead | input | 1 | 32-bit padding: 0 repeat the last bit, 1 repeat the first bit |
| cfg_ws_early | input | 1 | Select change leads the first data bit by one bit clock |
| cfg_left_high | input | 1 | Select level marking the left word |
| cfg_rise_change | input | 1 | Select and data change on rising bit-clock edges |
| bclk | input | 1 | Serial bit clock |
| wsel | input | 1 | Word select |
| wr_en | input | 1 | Holding register write strobe |
| wr_lane | input | LW | Lane addressed by the write |
| wr_data | input | DW | Sample written to the holding register |
| stat_rd | input | 1 | Status read strobe |
| sdo | output | LANES | Serial data per lane |
| left_empty | output | 1 | Left holding registers may be refilled |
| right_empty | output | 1 | Right holding registers may be refilled |
| underrun | output | 1 | Both flags set |

## Verification
The hardest state to reach from the ports is underrun and its two-step release. It needs a complete left/right pair to go out with no refill between the loads. Then a write must arrive both before and after a status read, while the bit clock is held still so no further load can change the flags. The stimulus runs a real frame sequence, stops the bit clock mid-word, and probes the flags after each host action. Early-select timing is the other difficult case. The select change has to lead the data by a full bit clock, so every frame is started from a preamble of several right-level ticks, and the select history is always known before the first left load.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [1:0] {
    WL_SHORT    = 2'd0,
    WL_NATIVE   = 2'd1,
    WL_LONG     = 2'd2,
    WL_LONG_ALT = 2'd3
  } wlen_e;
endpackage

// File: rtl/smt_frame_ctrl.sv
module smt_frame_ctrl #(
  parameter int DW   = 24,
  parameter int PADB = 8,
  localparam int CW  = $clog2(DW + PADB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  smt_pkg::wlen_e wlen,
  input  logic          pad_lead,
  input  logic          ws_early,
  input  logic          left_high,
  input  logic          rise_change,
  input  logic          bclk,
  input  logic          wsel,
  output logic          tick,
  output logic          load,
  output logic          load_left,
  output logic          step,
  output logic          busy
);
  import smt_pkg::*;

  logic          bclk_s, bclk_d, ws_s, ws_h1, ws_h2;
  logic          expect_left;
  logic [CW-1:0] cnt, last_idx;
  logic          ws_now, ws_before, want_lvl, start_ok, at_last, shift_ok, long_mode;

  always_comb begin
    case (wlen)
      WL_SHORT:  last_idx = CW'(DW - PADB - 1);
      WL_NATIVE: last_idx = CW'(DW - 1);
      default:   last_idx = CW'(DW + PADB - 1);
    endcase
  end

  assign long_mode = (wlen == WL_LONG) || (wlen == WL_LONG_ALT);
  assign tick      = rise_change ? (bclk_s & ~bclk_d) : (~bclk_s & bclk_d);
  // In early mode the select history is read one bit clock late.
  assign ws_now    = ws_early ? ws_h1 : ws_s;
  assign ws_before = ws_early ? ws_h2 : ws_h1;
  assign want_lvl  = expect_left ? left_high : ~left_high;
  assign start_ok  = (ws_now != ws_before) && (ws_now == want_lvl);
  assign at_last   = (cnt == last_idx);
  assign shift_ok  = !long_mode ||
                     (pad_lead ? (cnt >= CW'(PADB)) : (cnt < CW'(DW - 1)));
  assign load      = active & tick & (~busy | at_last) & start_ok;
  assign load_left = expect_left;
  assign step      = active & tick & busy & ~at_last & shift_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_s      <= 1'b0;
      bclk_d      <= 1'b0;
      ws_s        <= 1'b0;
      ws_h1       <= 1'b0;
      ws_h2       <= 1'b0;
      busy        <= 1'b0;
      cnt         <= '0;
      expect_left <= 1'b1;
    end else begin
      bclk_s <= bclk;
      bclk_d <= bclk_s;
      ws_s   <= wsel;
      if (tick) begin
        ws_h1 <= ws_s;
        ws_h2 <= ws_h1;
      end
      if (!active) begin
        busy        <= 1'b0;
        cnt         <= '0;
        expect_left <= 1'b1;
      end else if (tick) begin
        if (busy && !at_last) begin
          cnt <= cnt + 1'b1;
        end else if (start_ok) begin
          busy        <= 1'b1;
          cnt         <= '0;
          expect_left <= ~expect_left;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/smt_lane.sv
module smt_lane #(
  parameter int DW   = 24,
  parameter int PADB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lane_on,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  input  logic          step,
  input  logic          busy,
  input  logic          lsb_first,
  input  logic          short_mode,
  output logic          sdo
);
  logic [DW-1:0] hold, sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      sr   <= '0;
    end else begin
      if (wr) hold <= wr_data;
      if (load) begin
        // Short frames sent low-index first start at bit PADB.
        sr <= (lsb_first && short_mode) ? (hold >> PADB) : hold;
      end else if (step) begin
        sr <= lsb_first ? (sr >> 1) : (sr << 1);
      end
    end
  end

  assign sdo = !lane_on ? 1'b1 :
               busy     ? (lsb_first ? sr[0] : sr[DW-1]) : 1'b0;
endmodule

// File: rtl/smt_flags.sv
module smt_flags (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic load,
  input  logic load_left,
  input  logic wr,
  input  logic stat_rd,
  output logic left_empty,
  output logic right_empty,
  output logic underrun
);
  logic armed, le_n, re_n, arm_n;

  always_comb begin
    le_n  = left_empty;
    re_n  = right_empty;
    arm_n = armed;
    if (stat_rd && left_empty && right_empty) arm_n = 1'b1;
    if (wr) begin
      if (left_empty && right_empty) begin
        if (armed) begin
          le_n  = 1'b0;
          re_n  = 1'b0;
          arm_n = 1'b0;
        end
      end else begin
        le_n = 1'b0;
        re_n = 1'b0;
      end
    end
    if (load) begin
      if (load_left) re_n = 1'b1;
      else           le_n = 1'b1;
    end
    if (!(le_n && re_n)) arm_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      left_empty  <= 1'b0;
      right_empty <= 1'b0;
      underrun    <= 1'b0;
      armed       <= 1'b0;
    end else begin
      left_empty  <= le_n;
      right_empty <= re_n;
      underrun    <= le_n & re_n;
      armed       <= arm_n;
    end
  end
endmodule

// File: rtl/stereo_multilane_tx.sv
module stereo_multilane_tx #(
  parameter int LANES = 3,
  parameter int DW    = 24,
  parameter int PADB  = 8,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_en,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_lsb_first,
  input  logic             cfg_pad_lead,
  input  logic             cfg_ws_early,
  input  logic             cfg_left_high,
  input  logic             cfg_rise_change,
  input  logic             bclk,
  input  logic             wsel,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_lane,
  input  logic [DW-1:0]    wr_data,
  input  logic             stat_rd,
  output logic [LANES-1:0] sdo,
  output logic             left_empty,
  output logic             right_empty,
  output logic             underrun
);
  import smt_pkg::*;

  wlen_e wlen;
  logic  active, tick_w, load_w, load_left_w, step_w, busy_w, short_mode;

  assign wlen       = wlen_e'(cfg_wlen);
  assign active     = |lane_en;
  assign short_mode = (wlen == WL_SHORT);

  smt_frame_ctrl #(.DW(DW), .PADB(PADB)) u_ctrl (
    .clk(clk), .rst(rst), .active(active), .wlen(wlen),
    .pad_lead(cfg_pad_lead), .ws_early(cfg_ws_early),
    .left_high(cfg_left_high), .rise_change(cfg_rise_change),
    .bclk(bclk), .wsel(wsel), .tick(tick_w), .load(load_w),
    .load_left(load_left_w), .step(step_w), .busy(busy_w)
  );

  smt_flags u_flags (
    .clk(clk), .rst(rst), .active(active), .load(load_w),
    .load_left(load_left_w), .wr(wr_en), .stat_rd(stat_rd),
    .left_empty(left_empty), .right_empty(right_empty), .underrun(underrun)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    smt_lane #(.DW(DW), .PADB(PADB)) u_lane (
      .clk(clk), .rst(rst), .lane_on(lane_en[i]),
      .wr(wr_en && (wr_lane == LW'(i))), .wr_data(wr_data),
      .load(load_w), .step(step_w), .busy(busy_w),
      .lsb_first(cfg_lsb_first), .short_mode(short_mode), .sdo(sdo[i])
    );
  end
endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
  parameter int LANES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] sdo,
  input logic             left_empty,
  input logic             right_empty,
  input logic             underrun,
  input logic             load,
  input logic             load_left,
  input logic             tick
);
  // R11: local reset clears both flags
  assert_flags_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (lane_en == '0) |=> (!left_empty && !right_empty));

  // R6: loading left words frees the right holding slot
  assert_left_load_R6: assert property (@(posedge clk) disable iff (rst)
    (load && load_left) |=> right_empty);

  // R6: loading right words frees the left holding slot
  assert_right_load_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !load_left) |=> left_empty);

  // R8: underrun only rises as a result of a shift-register load
  assert_underrun_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(load));

  // R12: lanes change only after a bit-clock change edge
  assert_sdo_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && ($past(lane_en) == lane_en) && ($past(lane_en, 2) == lane_en))
      |-> $stable(sdo));
endmodule

bind stereo_multilane_tx smt_checker #(.LANES(LANES)) u_smt_checker (
  .clk(clk), .rst(rst), .lane_en(lane_en), .sdo(sdo),
  .left_empty(left_empty), .right_empty(right_empty), .underrun(underrun),
  .load(load_w), .load_left(load_left_w), .tick(tick_w)
);

// File: tb/stereo_multilane_tx_bench.sv
module stereo_multilane_tx_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  lane_en;
  logic [1:0]  cfg_wlen;
  logic        cfg_lsb_first, cfg_pad_lead, cfg_ws_early, cfg_left_high, cfg_rise_change;
  logic        bclk, wsel, wr_en, stat_rd;
  logic [1:0]  wr_lane;
  logic [23:0] wr_data;
  logic [2:0]  sdo;
  logic        left_empty, right_empty, underrun;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  stereo_multilane_tx u_stereo_multilane_tx (
    .clk(clk), .rst(rst), .lane_en(lane_en), .cfg_wlen(cfg_wlen),
    .cfg_lsb_first(cfg_lsb_first), .cfg_pad_lead(cfg_pad_lead),
    .cfg_ws_early(cfg_ws_early), .cfg_left_high(cfg_left_high),
    .cfg_rise_change(cfg_rise_change), .bclk(bclk), .wsel(wsel),
    .wr_en(wr_en), .wr_lane(wr_lane), .wr_data(wr_data), .stat_rd(stat_rd),
    .sdo(sdo), .left_empty(left_empty), .right_empty(right_empty),
    .underrun(underrun)
  );

  typedef struct packed {
    logic [1:0]  wl;
    logic        lsb;
    logic        lead;
    logic        early;
    logic        lhigh;
    logic        rise;
    logic [2:0]  en;
    logic [23:0] ld;
    logic [23:0] rd;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 24'hA5C3F1, 24'h3C5A96},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 24'h9ABCDE, 24'h13579B},
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b111, 24'h6D2E81, 24'hF04C37},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 24'hB3C5A7, 24'h5E6F10},
    '{2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 24'h52D0C3, 24'h7A8E14},
    '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'b101, 24'hC8E2F5, 24'h1B3D59},
    '{2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010, 24'hE9A4B6, 24'h2F7C80}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int lane, input logic [23:0] d);
    wr_lane = 2'(lane);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // One bit clock: idle half, then the change edge with the new select level.
  task automatic bit_tick(input logic w);
    bclk = cfg_rise_change ? 1'b0 : 1'b1;
    cyc(3);
    bclk = cfg_rise_change ? 1'b1 : 1'b0;
    wsel = w;
    cyc(3);
  endtask

  function automatic int frame_len(input logic [1:0] wl);
    return (wl == 2'b00) ? 16 : (wl == 2'b01) ? 24 : 32;
  endfunction

  function automatic logic [23:0] lane_val(input logic [23:0] d, input int lane);
    return d ^ {8{3'(lane)}};
  endfunction

  // Expected serial sequence, position j holds the j-th bit sent (R1, R2).
  function automatic logic [31:0] exp_seq(input logic [1:0] wl, input logic lsb,
                                          input logic lead, input logic [23:0] w);
    logic [31:0] r;
    int n, k;
    r = '0;
    n = frame_len(wl);
    for (int j = 0; j < n; j++) begin
      k = j;
      if (n == 32) k = lead ? ((j < 8) ? 0 : j - 8) : ((j > 23) ? 23 : j);
      r[j] = lsb ? w[(n == 16) ? k + 8 : k] : w[23 - k];
    end
    return r;
  endfunction

  task automatic run_vector(input vec_t v);
    logic [31:0] got_l [3];
    logic [31:0] got_r [3];
    logic [31:0] ones;
    logic        ws;
    int n, wi;
    n    = frame_len(v.wl);
    ones = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    for (int i = 0; i < 3; i++) begin
      got_l[i] = '0;
      got_r[i] = '0;
    end
    lane_en         = 3'b000;
    cfg_wlen        = v.wl;
    cfg_lsb_first   = v.lsb;
    cfg_pad_lead    = v.lead;
    cfg_ws_early    = v.early;
    cfg_left_high   = v.lhigh;
    cfg_rise_change = v.rise;
    cyc(2);
    // R5: holding data written while disabled
    for (int i = 0; i < 3; i++) wr(i, lane_val(v.ld, i));
    lane_en = v.en;
    cyc(2);
    for (int t = -3; t <= 2 * n; t++) begin
      wi = t + int'(v.early);
      ws = (wi >= 0 && wi < n) ? v.lhigh : ~v.lhigh;
      bit_tick(ws);
      for (int i = 0; i < 3; i++) begin
        if (t >= 0 && t < n)          got_l[i][t]     = sdo[i];
        else if (t >= n && t < 2 * n) got_r[i][t - n] = sdo[i];
      end
      if (t == 0) begin
        chk("R6 right_empty after left load", {31'd0, right_empty}, 32'd1);
        chk("R6 left_empty stays low", {31'd0, left_empty}, 32'd0);
        for (int i = 0; i < 3; i++) wr(i, lane_val(v.rd, i));
        chk("R7 single flag cleared by write", {31'd0, right_empty}, 32'd0);
      end
      if (t == n) chk("R6 left_empty after right load", {31'd0, left_empty}, 32'd1);
      if (t == 2 * n) chk("R10 idle lanes low, disabled high", {29'd0, sdo}, {29'd0, ~v.en});
    end
    // R1 R2 R3 R4 R5 R12: every lane, both words, same ticks
    for (int i = 0; i < 3; i++) begin
      if (v.en[i]) begin
        chk("R1 R2 R3 R4 R5 R12 left word", got_l[i], exp_seq(v.wl, v.lsb, v.lead, lane_val(v.ld, i)));
        chk("R1 R2 R3 R4 R12 right word", got_r[i], exp_seq(v.wl, v.lsb, v.lead, lane_val(v.rd, i)));
      end else begin
        chk("R10 disabled lane high (left)", got_l[i], ones);
        chk("R10 disabled lane high (right)", got_r[i], ones);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog all requirements got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] seq;
    rst = 1'b1; lane_en = 3'b000; cfg_wlen = 2'b01; cfg_lsb_first = 1'b0;
    cfg_pad_lead = 1'b0; cfg_ws_early = 1'b0; cfg_left_high = 1'b0;
    cfg_rise_change = 1'b0; bclk = 1'b1; wsel = 1'b1; wr_en = 1'b0;
    wr_lane = 2'd0; wr_data = '0; stat_rd = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(2);
    chk("R11 reset flags", {30'd0, left_empty, right_empty}, 32'd0);
    chk("R11 reset underrun", {31'd0, underrun}, 32'd0);
    chk("R10 reset lanes high", {29'd0, sdo}, 32'd7);

    for (int vi = 0; vi < 7; vi++) run_vector(VECS[vi]);

    // R8 R9: underrun, stale data, two-step release
    lane_en = 3'b000; cfg_wlen = 2'b01; cfg_lsb_first = 1'b0; cfg_pad_lead = 1'b0;
    cfg_ws_early = 1'b0; cfg_left_high = 1'b0; cfg_rise_change = 1'b0;
    cyc(2);
    for (int i = 0; i < 3; i++) wr(i, 24'h4F0E31);
    lane_en = 3'b111;
    cyc(2);
    for (int t = 0; t < 3; t++) bit_tick(1'b1);
    seq = '0;
    for (int t = 0; t < 24; t++) begin
      bit_tick(1'b0);
      seq[t] = sdo[0];
    end
    chk("R5 left word from disabled-time write", seq, exp_seq(2'b01, 1'b0, 1'b0, 24'h4F0E31));
    seq = '0;
    for (int t = 0; t < 24; t++) begin
      bit_tick(1'b1);
      seq[t] = sdo[0];
      if (t == 0) begin
        chk("R8 underrun raised", {31'd0, underrun}, 32'd1);
        chk("R8 both flags set", {30'd0, left_empty, right_empty}, 32'd3);
      end
    end
    chk("R8 stale holding data resent", seq, exp_seq(2'b01, 1'b0, 1'b0, 24'h4F0E31));
    wr(0, 24'hC0FFEE);
    cyc(1);
    chk("R9 write alone keeps flags", {30'd0, left_empty, right_empty}, 32'd3);
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
    wr(0, 24'hC0FFEE);
    cyc(1);
    chk("R9 status then write clears", {29'd0, underrun, left_empty, right_empty}, 32'd0);

    // R11: local reset clears a set flag
    bit_tick(1'b0);
    chk("R6 flag set before disable", {31'd0, right_empty}, 32'd1);
    lane_en = 3'b000;
    cyc(2);
    chk("R11 disable clears flags", {29'd0, underrun, left_empty, right_empty}, 32'd0);
    chk("R10 all disabled lanes high", {29'd0, sdo}, 32'd7);

    // R5: a right-word select change after enable is ignored
    lane_en = 3'b111;
    cyc(2);
    bit_tick(1'b0);
    bit_tick(1'b0);
    bit_tick(1'b1);
    bit_tick(1'b1);
    chk("R5 right change ignored, lanes idle", {29'd0, sdo}, 32'd0);
    chk("R5 no load before left", {30'd0, left_empty, right_empty}, 32'd0);
    bit_tick(1'b0);
    chk("R5 first load is left", {30'd0, left_empty, right_empty}, 32'd1);
    chk("R5 R12 first bits of all lanes", {29'd0, sdo}, 32'd1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule